// File: doc/BRIEF.md
# Move-to-Front Translation Buffer with Walk Caching

This block is a small fully associative address translation buffer. Its slots form one ordered list, most recently used first. A lookup compares a virtual page number, an address-space ID, a virtual-machine ID and a translation regime against every slot at the same time. One clock later it reports hit or miss, the slot it found, the physical frame, the lookup level and the access type.

Walk results go in through a fill port. Each fill is always placed at the head of the list and pushes every other slot one place down. Intermediate-level (partial) walk results share the same slots as complete translations. A partial result is kept only when its level is enabled in a configuration mask. An invalidate port clears every slot, or only the slots that belong to a given VMID and regime, and optionally to a given ASID.

Counters record hits and misses for each access kind, partial hits, invalidate requests and cleared slots. Debug (functional) lookups leave all state unchanged.

Top module: `mtf_tlb`

## Requirements
- R1: A slot matches when it is valid, its regime and VMID equal the request, and its page number equals the request page number with the low `sz*4` bits ignored (sz is the slot's 2-bit size code). Its ASID must also equal the request ASID, unless the slot is global.
- R2: The result appears on `rs_*` in the cycle after `lk_valid`, with `rs_valid` high. `rs_idx` is the slot position before any reordering. On a miss, `rs_hit`, `rs_idx`, `rs_pfn`, `rs_lvl` and `rs_type` are all zero.
- R3: Level 3 is a complete translation and levels 0 to 2 are partial. The first matching complete slot wins over any partial slot. Among partial slots, the deepest level wins, and between slots at the same level the one at the higher position wins.
- R4: A non-functional hit at a position above `MRU_WIN` (default 1) moves the hit slot to position 0 and shifts the slots in front of it down by one. A hit at or below `MRU_WIN` keeps the order.
- R5: An accepted fill is written to position 0. Every slot shifts down by one, and the last slot is discarded whether it is valid or not.
- R6: A fill at level 3 is always accepted. A fill at level n < 3 is accepted only when bit n of `PART_MASK` is set. The default mask enables levels 1 and 2 and drops level 0.
- R7: Type codes are 01 instruction, 10 data and 11 unified. Access modes are 0 read, 1 write and 2 instruction. A non-functional hit whose access kind is not in the slot's type makes the slot unified, and `rs_type` reports that new type.
- R8: A functional lookup is still answered, but it changes no order, no type and no counter.
- R9: Every non-functional lookup adds one to exactly one counter: the hit or the miss counter of its mode (read, write or instruction). A hit on a partial slot also adds one to `cnt_hit_part`.
- R10: `iv_all` clears every slot. `iv_sel` clears the valid slots whose VMID and regime match; when `iv_use_asid` is set, only non-global slots with a matching ASID are cleared. Each request adds one to `cnt_inv_req`, and `cnt_inv_ent` grows by the number of slots cleared.
- R11: In one cycle, an invalidate takes priority over a fill, and a fill takes priority over a move-to-front or a type change. A lookup made in that cycle is still answered from the table as it was before the update.
- R12: A synchronous reset clears all slots and all counters, so every lookup afterwards misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup page number |
| lk_asid | input | ASID_W | Lookup address-space ID |
| lk_vmid | input | VMID_W | Lookup VMID |
| lk_regime | input | 2 | Lookup translation regime |
| lk_mode | input | 2 | 0 read, 1 write, 2 instruction |
| lk_func | input | 1 | Functional (debug) lookup |
| rs_valid | output | 1 | Result valid |
| rs_hit | output | 1 | Hit |
| rs_idx | output | IDX_W | Slot position of the hit |
| rs_pfn | output | PFN_W | Physical frame of the hit |
| rs_lvl | output | LVL_W | Lookup level of the hit |
| rs_type | output | 2 | Access type of the slot after the hit |
| in_valid | input | 1 | Fill request |
| in_vpn | input | VPN_W | Fill page number |
| in_asid | input | ASID_W | Fill ASID |
| in_vmid | input | VMID_W | Fill VMID |
| in_regime | input | 2 | Fill regime |
| in_global | input | 1 | Fill is global |
| in_size | input | 2 | Fill size code |
| in_pfn | input | PFN_W | Fill physical frame |
| in_lvl | input | LVL_W | Fill lookup level |
| in_type | input | 2 | Fill access type |
| iv_all | input | 1 | Invalidate all slots |
| iv_sel | input | 1 | Selective invalidate |
| iv_vmid | input | VMID_W | Selective VMID |
| iv_regime | input | 2 | Selective regime |
| iv_use_asid | input | 1 | Also match ASID |
| iv_asid | input | ASID_W | Selective ASID |
| cnt_hit_rd | output | CNT_W | Read hits |
| cnt_hit_wr | output | CNT_W | Write hits |
| cnt_hit_ex | output | CNT_W | Instruction hits |
| cnt_miss_rd | output | CNT_W | Read misses |
| cnt_miss_wr | output | CNT_W | Write misses |
| cnt_miss_ex | output | CNT_W | Instruction misses |
| cnt_hit_part | output | CNT_W | Partial hits |
| cnt_inv_req | output | CNT_W | Invalidate requests |
| cnt_inv_ent | output | CNT_W | Slots cleared |

## Verification
The assertions rely on inputs that are held low during reset, because several checks compare against the value a request had in the previous cycle. They also rely on the access mode being one of the three defined codes. The stimulus drives every input on the falling clock edge. It clears all request strobes during reset, and it uses only modes 0, 1 and 2. Same-cycle collisions of invalidate, fill and lookup are produced on purpose, so that the priority order is covered.

// File: rtl/mtf_tlb.sv
module mtf_tlb #(
  parameter int ENTRIES = 8,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int ASID_W = 8,
  parameter int VMID_W = 8,
  parameter int LEVELS = 4,
  parameter int SZ_STEP = 4,
  parameter int MRU_WIN = 1,
  parameter int CNT_W = 16,
  parameter logic [LEVELS-1:0] PART_MASK = 4'b0110,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VMID_W-1:0] lk_vmid,
  input  logic [1:0]        lk_regime,
  input  logic [1:0]        lk_mode,
  input  logic              lk_func,
  output logic              rs_valid,
  output logic              rs_hit,
  output logic [IDX_W-1:0]  rs_idx,
  output logic [PFN_W-1:0]  rs_pfn,
  output logic [LVL_W-1:0]  rs_lvl,
  output logic [1:0]        rs_type,
  input  logic              in_valid,
  input  logic [VPN_W-1:0]  in_vpn,
  input  logic [ASID_W-1:0] in_asid,
  input  logic [VMID_W-1:0] in_vmid,
  input  logic [1:0]        in_regime,
  input  logic              in_global,
  input  logic [1:0]        in_size,
  input  logic [PFN_W-1:0]  in_pfn,
  input  logic [LVL_W-1:0]  in_lvl,
  input  logic [1:0]        in_type,
  input  logic              iv_all,
  input  logic              iv_sel,
  input  logic [VMID_W-1:0] iv_vmid,
  input  logic [1:0]        iv_regime,
  input  logic              iv_use_asid,
  input  logic [ASID_W-1:0] iv_asid,
  output logic [CNT_W-1:0]  cnt_hit_rd,
  output logic [CNT_W-1:0]  cnt_hit_wr,
  output logic [CNT_W-1:0]  cnt_hit_ex,
  output logic [CNT_W-1:0]  cnt_miss_rd,
  output logic [CNT_W-1:0]  cnt_miss_wr,
  output logic [CNT_W-1:0]  cnt_miss_ex,
  output logic [CNT_W-1:0]  cnt_hit_part,
  output logic [CNT_W-1:0]  cnt_inv_req,
  output logic [CNT_W-1:0]  cnt_inv_ent
);

  localparam logic [LVL_W-1:0] LAST = LVL_W'(LEVELS - 1);

  typedef struct packed {
    logic              v;
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [VMID_W-1:0] vmid;
    logic [1:0]        rg;
    logic              g;
    logic [1:0]        sz;
    logic [PFN_W-1:0]  pfn;
    logic [LVL_W-1:0]  lvl;
    logic [1:0]        ty;
  } slot_t;

  slot_t tbl [ENTRIES];

  logic [ENTRIES-1:0] mv, sm, clr, vld;
  logic               cfound, pfound, hit;
  logic [IDX_W-1:0]   cidx, pidx, hidx;
  logic [LVL_W-1:0]   plvl;
  slot_t              he, ne;
  logic [1:0]         kind, pty;
  logic               in_ok, inv, upd;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      logic [VPN_W-1:0] vm;
      vm = VPN_W'({VPN_W{1'b1}} << (SZ_STEP * int'(tbl[i].sz)));
      vld[i] = tbl[i].v;
      mv[i] = tbl[i].v && (((tbl[i].vpn ^ lk_vpn) & vm) == '0) &&
              tbl[i].rg == lk_regime && tbl[i].vmid == lk_vmid &&
              (tbl[i].g || tbl[i].asid == lk_asid);
      sm[i] = tbl[i].v && tbl[i].vmid == iv_vmid && tbl[i].rg == iv_regime &&
              (!iv_use_asid || (!tbl[i].g && tbl[i].asid == iv_asid));
    end
  end

  always_comb begin
    cfound = 1'b0; cidx = '0;
    pfound = 1'b0; pidx = '0; plvl = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!cfound && mv[i] && tbl[i].lvl == LAST) begin
        cfound = 1'b1;
        cidx = IDX_W'(i);
      end
      if (mv[i] && tbl[i].lvl != LAST && (!pfound || tbl[i].lvl >= plvl)) begin
        pfound = 1'b1;
        pidx = IDX_W'(i);
        plvl = tbl[i].lvl;
      end
    end
  end

  assign hit   = lk_valid && (cfound || pfound);
  assign hidx  = cfound ? cidx : pidx;
  assign he    = tbl[hidx];
  assign kind  = (lk_mode == 2'd2) ? 2'b01 : 2'b10;
  assign pty   = ((he.ty & kind) != 2'b00) ? he.ty : 2'b11;
  assign in_ok = in_valid && (in_lvl == LAST || PART_MASK[in_lvl]);
  assign inv   = iv_all || iv_sel;
  assign clr   = iv_all ? vld : sm;
  assign upd   = hit && !lk_func;
  assign ne    = '{v: 1'b1, vpn: in_vpn, asid: in_asid, vmid: in_vmid, rg: in_regime,
                   g: in_global, sz: in_size, pfn: in_pfn, lvl: in_lvl, ty: in_type};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
    end else if (inv) begin
      for (int i = 0; i < ENTRIES; i++)
        if (clr[i]) tbl[i].v <= 1'b0;
    end else if (in_ok) begin
      tbl[0] <= ne;
      for (int i = 1; i < ENTRIES; i++) tbl[i] <= tbl[i-1];
    end else if (upd) begin
      if (int'(hidx) > MRU_WIN) begin
        tbl[0] <= he;
        tbl[0].ty <= pty;
        for (int i = 1; i < ENTRIES; i++)
          if (i <= int'(hidx)) tbl[i] <= tbl[i-1];
      end else begin
        tbl[hidx].ty <= pty;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rs_valid <= 1'b0; rs_hit <= 1'b0; rs_idx <= '0;
      rs_pfn <= '0; rs_lvl <= '0; rs_type <= '0;
    end else begin
      rs_valid <= lk_valid;
      rs_hit   <= hit;
      rs_idx   <= hit ? hidx : '0;
      rs_pfn   <= hit ? he.pfn : '0;
      rs_lvl   <= hit ? he.lvl : '0;
      rs_type  <= hit ? (lk_func ? he.ty : pty) : 2'b00;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_hit_rd <= '0; cnt_hit_wr <= '0; cnt_hit_ex <= '0;
      cnt_miss_rd <= '0; cnt_miss_wr <= '0; cnt_miss_ex <= '0;
      cnt_hit_part <= '0; cnt_inv_req <= '0; cnt_inv_ent <= '0;
    end else begin
      if (lk_valid && !lk_func) begin
        if (hit) begin
          if (lk_mode == 2'd2) cnt_hit_ex <= cnt_hit_ex + 1'b1;
          else if (lk_mode == 2'd1) cnt_hit_wr <= cnt_hit_wr + 1'b1;
          else cnt_hit_rd <= cnt_hit_rd + 1'b1;
          if (he.lvl != LAST) cnt_hit_part <= cnt_hit_part + 1'b1;
        end else begin
          if (lk_mode == 2'd2) cnt_miss_ex <= cnt_miss_ex + 1'b1;
          else if (lk_mode == 2'd1) cnt_miss_wr <= cnt_miss_wr + 1'b1;
          else cnt_miss_rd <= cnt_miss_rd + 1'b1;
        end
      end
      if (inv) begin
        cnt_inv_req <= cnt_inv_req + 1'b1;
        cnt_inv_ent <= cnt_inv_ent + CNT_W'($countones(clr));
      end
    end
  end

  logic [VPN_W-1:0] hit_vpn;
  logic [PFN_W-1:0] hit_pfn;
  assign hit_vpn = he.vpn;
  assign hit_pfn = he.pfn;

  // R10
  inv_all_chk: assert property (@(posedge clk) disable iff (rst)
    iv_all |=> (vld == '0));

  // R5
  ins_front_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && in_ok && !inv) |=> (tbl[0].v && tbl[0].vpn == $past(in_vpn) && tbl[0].pfn == $past(in_pfn)));

  // R4
  mtf_front_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && upd && int'(hidx) > MRU_WIN && !in_ok && !inv)
      |=> (tbl[0].vpn == $past(hit_vpn) && tbl[0].pfn == $past(hit_pfn)));

  // R8
  func_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && lk_valid && lk_func && !inv) |=>
      ($stable(cnt_hit_rd) && $stable(cnt_hit_wr) && $stable(cnt_hit_ex) &&
       $stable(cnt_miss_rd) && $stable(cnt_miss_wr) && $stable(cnt_miss_ex) &&
       $stable(cnt_hit_part)));

  // R2
  rs_hit_chk: assert property (@(posedge clk) disable iff (rst)
    rs_hit |-> rs_valid);

endmodule

// File: tb/mtf_tlb_tb_top.sv
module mtf_tlb_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic lk_valid = 0, lk_func = 0;
  logic [19:0] lk_vpn = 0; logic [7:0] lk_asid = 0, lk_vmid = 0;
  logic [1:0] lk_regime = 0, lk_mode = 0;
  logic rs_valid, rs_hit; logic [2:0] rs_idx; logic [19:0] rs_pfn;
  logic [1:0] rs_lvl, rs_type;
  logic in_valid = 0, in_global = 0;
  logic [19:0] in_vpn = 0, in_pfn = 0; logic [7:0] in_asid = 0, in_vmid = 0;
  logic [1:0] in_regime = 0, in_size = 0, in_lvl = 0, in_type = 0;
  logic iv_all = 0, iv_sel = 0, iv_use_asid = 0;
  logic [7:0] iv_vmid = 0, iv_asid = 0; logic [1:0] iv_regime = 0;
  logic [15:0] cnt_hit_rd, cnt_hit_wr, cnt_hit_ex, cnt_miss_rd, cnt_miss_wr,
               cnt_miss_ex, cnt_hit_part, cnt_inv_req, cnt_inv_ent;

  mtf_tlb dut_i (.*);

  typedef struct packed {
    bit v; bit [19:0] vpn; bit [7:0] asid; bit [7:0] vmid; bit [1:0] rg;
    bit g; bit [1:0] sz; bit [19:0] pfn; bit [1:0] lvl; bit [1:0] ty;
  } me_t;
  typedef struct packed {
    bit h; bit [2:0] idx; bit [19:0] pfn; bit [1:0] lvl; bit [1:0] ty;
  } ex_t;

  localparam bit [3:0] PMASK = 4'b0110;
  me_t m [8];
  int c_hr, c_hw, c_hx, c_mr, c_mw, c_mx, c_hp, c_ir, c_ie;
  int n_chk = 0, n_bad = 0;
  ex_t exp_q[$];
  string tag_q[$];

  function automatic bit m_match(int i, bit [19:0] vpn, bit [7:0] asid, bit [7:0] vmid, bit [1:0] rg);
    bit [19:0] mk;
    mk = 20'hFFFFF << (int'(m[i].sz) * 4);
    return m[i].v && (((m[i].vpn ^ vpn) & mk) == 0) && m[i].rg == rg &&
           m[i].vmid == vmid && (m[i].g || m[i].asid == asid);
  endfunction

  function automatic void m_insert(me_t e);
    if (e.lvl == 2'd3 || PMASK[e.lvl]) begin
      for (int i = 7; i > 0; i--) m[i] = m[i-1];
      m[0] = e;
    end
  endfunction

  task automatic check(bit ok, string tag, string detail);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s", tag, detail);
    end
  endtask

  task automatic lookup_op(bit [19:0] vpn, bit [7:0] asid, bit [7:0] vmid, bit [1:0] rg,
                           bit [1:0] mode, bit fn, bit with_ins, me_t ie, string tag);
    int ci, pi; bit cf, pf; bit h; int idx; ex_t e; bit [1:0] kd, pty;
    cf = 0; pf = 0; ci = 0; pi = 0;
    for (int i = 0; i < 8; i++) begin
      if (m_match(i, vpn, asid, vmid, rg)) begin
        if (m[i].lvl == 2'd3) begin
          if (!cf) begin cf = 1; ci = i; end
        end else if (!pf || m[i].lvl >= m[pi].lvl) begin
          pf = 1; pi = i;
        end
      end
    end
    h = cf || pf; idx = cf ? ci : pi;
    kd = (mode == 2'd2) ? 2'b01 : 2'b10;
    e = '0;
    if (h) begin
      pty = ((m[idx].ty & kd) != 0) ? m[idx].ty : 2'b11;
      e.h = 1; e.idx = 3'(idx); e.pfn = m[idx].pfn; e.lvl = m[idx].lvl;
      e.ty = fn ? m[idx].ty : pty;
    end
    exp_q.push_back(e); tag_q.push_back(tag);
    if (!fn) begin
      if (h) begin
        if (mode == 2) c_hx++; else if (mode == 1) c_hw++; else c_hr++;
        if (m[idx].lvl != 2'd3) c_hp++;
      end else begin
        if (mode == 2) c_mx++; else if (mode == 1) c_mw++; else c_mr++;
      end
    end
    if (with_ins) m_insert(ie);
    else if (!fn && h) begin
      if (idx > 1) begin
        me_t t; t = m[idx]; t.ty = pty;
        for (int i = idx; i > 0; i--) m[i] = m[i-1];
        m[0] = t;
      end else m[idx].ty = pty;
    end
    lk_valid = 1; lk_vpn = vpn; lk_asid = asid; lk_vmid = vmid; lk_regime = rg;
    lk_mode = mode; lk_func = fn;
    if (with_ins) drive_ins(ie);
    @(negedge clk);
    lk_valid = 0; lk_func = 0; in_valid = 0;
  endtask

  task automatic drive_ins(me_t e);
    in_valid = 1; in_vpn = e.vpn; in_asid = e.asid; in_vmid = e.vmid; in_regime = e.rg;
    in_global = e.g; in_size = e.sz; in_pfn = e.pfn; in_lvl = e.lvl; in_type = e.ty;
  endtask

  function automatic me_t mk(bit [19:0] vpn, bit [7:0] asid, bit [7:0] vmid, bit [1:0] rg,
                             bit g, bit [1:0] sz, bit [19:0] pfn, bit [1:0] lvl, bit [1:0] ty);
    me_t e;
    e.v = 1; e.vpn = vpn; e.asid = asid; e.vmid = vmid; e.rg = rg; e.g = g;
    e.sz = sz; e.pfn = pfn; e.lvl = lvl; e.ty = ty;
    return e;
  endfunction

  task automatic ins_op(me_t e);
    m_insert(e);
    drive_ins(e);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic lk(bit [19:0] vpn, bit [7:0] asid, bit [7:0] vmid, bit [1:0] mode, string tag);
    lookup_op(vpn, asid, vmid, 2'd0, mode, 1'b0, 1'b0, '0, tag);
  endtask

  task automatic inv_op(bit all, bit [7:0] vmid, bit [1:0] rg, bit ua, bit [7:0] asid,
                        bit with_ins, me_t ie);
    c_ir++;
    for (int i = 0; i < 8; i++) begin
      bit s;
      s = m[i].v && (all || (m[i].vmid == vmid && m[i].rg == rg &&
                     (!ua || (!m[i].g && m[i].asid == asid))));
      if (s) begin m[i].v = 0; c_ie++; end
    end
    iv_all = all; iv_sel = !all; iv_vmid = vmid; iv_regime = rg; iv_use_asid = ua; iv_asid = asid;
    if (with_ins) drive_ins(ie);
    @(negedge clk);
    iv_all = 0; iv_sel = 0; in_valid = 0;
  endtask

  task automatic chk_cnt(string tag);
    check({cnt_hit_rd, cnt_hit_wr, cnt_hit_ex} == {16'(c_hr), 16'(c_hw), 16'(c_hx)}, tag,
          $sformatf("hits got %0d/%0d/%0d exp %0d/%0d/%0d", cnt_hit_rd, cnt_hit_wr, cnt_hit_ex, c_hr, c_hw, c_hx));
    check({cnt_miss_rd, cnt_miss_wr, cnt_miss_ex} == {16'(c_mr), 16'(c_mw), 16'(c_mx)}, tag,
          $sformatf("misses got %0d/%0d/%0d exp %0d/%0d/%0d", cnt_miss_rd, cnt_miss_wr, cnt_miss_ex, c_mr, c_mw, c_mx));
    check(cnt_hit_part == 16'(c_hp), tag, $sformatf("partial got %0d exp %0d", cnt_hit_part, c_hp));
    check({cnt_inv_req, cnt_inv_ent} == {16'(c_ir), 16'(c_ie)}, tag,
          $sformatf("inval got %0d/%0d exp %0d/%0d", cnt_inv_req, cnt_inv_ent, c_ir, c_ie));
  endtask

  always @(negedge clk) begin
    if (!rst && rs_valid) begin
      ex_t g, x; string t;
      g = {rs_hit, rs_idx, rs_pfn, rs_lvl, rs_type};
      if (exp_q.size() == 0) check(0, "R2", "result with no request got 1 exp 0");
      else begin
        x = exp_q.pop_front(); t = tag_q.pop_front();
        check(g == x, t, $sformatf("got h%0d i%0d p%0h l%0d t%0d exp h%0d i%0d p%0h l%0d t%0d",
              g.h, g.idx, g.pfn, g.lvl, g.ty, x.h, x.idx, x.pfn, x.lvl, x.ty));
      end
    end
  end

  initial begin
    #100000;
    check(0, "watchdog", "timeout got 1 exp 0");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    chk_cnt("R12 reset counters");
    lk(20'd1, 8'd1, 8'd1, 2'd0, "R12 miss after reset");
    // R5 fills and R4 move-to-front
    for (int k = 1; k <= 4; k++) ins_op(mk(20'(k*16), 8'd1, 8'd1, 2'd0, 0, 2'd0, 20'(256+k), 2'd3, 2'b10));
    lk(20'd16, 8'd1, 8'd1, 2'd0, "R4 far hit moves");
    lk(20'd64, 8'd1, 8'd1, 2'd1, "R4 near hit keeps order");
    lk(20'd16, 8'd1, 8'd1, 2'd1, "R4 moved slot at front");
    // R1 match rules
    lk(20'd32, 8'd2, 8'd1, 2'd0, "R1 asid mismatch");
    lookup_op(20'd32, 8'd1, 8'd1, 2'd2, 2'd0, 0, 0, '0, "R1 regime mismatch");
    lk(20'd32, 8'd1, 8'd7, 2'd0, "R1 vmid mismatch");
    ins_op(mk(20'd80, 8'd9, 8'd1, 2'd0, 1, 2'd0, 20'h500, 2'd3, 2'b10));
    lk(20'd80, 8'd3, 8'd1, 2'd0, "R1 global ignores asid");
    ins_op(mk(20'h123, 8'd1, 8'd1, 2'd0, 0, 2'd1, 20'h600, 2'd3, 2'b10));
    lk(20'h12F, 8'd1, 8'd1, 2'd0, "R1 size code masks low bits");
    lk(20'h133, 8'd1, 8'd1, 2'd0, "R1 size code upper bits differ");
    // R7 promotion
    ins_op(mk(20'd96, 8'd1, 8'd1, 2'd0, 0, 2'd0, 20'h700, 2'd3, 2'b01));
    lk(20'd96, 8'd1, 8'd1, 2'd0, "R7 read on instruction slot");
    lk(20'd96, 8'd1, 8'd1, 2'd2, "R7 unified stays");
    // R8 functional
    lookup_op(20'd48, 8'd1, 8'd1, 2'd0, 2'd2, 1, 0, '0, "R8 functional no promote");
    lk(20'd48, 8'd1, 8'd1, 2'd0, "R8 order unchanged by functional");
    chk_cnt("R8 R9 counters");
    // R6 R3 partial entries
    ins_op(mk(20'd112, 8'd1, 8'd1, 2'd0, 0, 2'd0, 20'h801, 2'd1, 2'b11));
    lk(20'd112, 8'd1, 8'd1, 2'd1, "R6 level 1 cached");
    ins_op(mk(20'd112, 8'd1, 8'd1, 2'd0, 0, 2'd0, 20'h800, 2'd0, 2'b11));
    lk(20'd112, 8'd1, 8'd1, 2'd1, "R6 level 0 dropped");
    ins_op(mk(20'd128, 8'd1, 8'd1, 2'd0, 0, 2'd0, 20'h903, 2'd3, 2'b10));
    ins_op(mk(20'd128, 8'd1, 8'd1, 2'd0, 0, 2'd0, 20'h902, 2'd2, 2'b11));
    lk(20'd128, 8'd1, 8'd1, 2'd0, "R3 complete beats partial");
    ins_op(mk(20'd144, 8'd1, 8'd1, 2'd0, 0, 2'd0, 20'hA01, 2'd1, 2'b11));
    ins_op(mk(20'd144, 8'd1, 8'd1, 2'd0, 0, 2'd0, 20'hA21, 2'd2, 2'b11));
    ins_op(mk(20'd144, 8'd1, 8'd1, 2'd0, 0, 2'd0, 20'hA22, 2'd2, 2'b11));
    lk(20'd144, 8'd1, 8'd1, 2'd2, "R3 deepest then higher position");
    lk(20'd999, 8'd1, 8'd1, 2'd2, "R9 instruction miss");
    lk(20'd999, 8'd1, 8'd1, 2'd1, "R9 write miss");
    chk_cnt("R9 counters by mode");
    // R11 fill beats move-to-front
    lookup_op(20'd112, 8'd1, 8'd1, 2'd0, 2'd0, 0, 1,
              mk(20'd160, 8'd1, 8'd1, 2'd0, 0, 2'd0, 20'hB00, 2'd3, 2'b10), "R11 lookup with fill");
    lk(20'd160, 8'd1, 8'd1, 2'd0, "R11 fill at front");
    lk(20'd112, 8'd1, 8'd1, 2'd0, "R11 hit slot not moved");
    // R5 eviction
    for (int k = 0; k < 8; k++) ins_op(mk(20'(300+k), 8'd1, 8'd1, 2'd0, 0, 2'd0, 20'(k), 2'd3, 2'b10));
    lk(20'd160, 8'd1, 8'd1, 2'd0, "R5 oldest evicted");
    lk(20'd300, 8'd1, 8'd1, 2'd0, "R5 last slot kept");
    // R10 selective and full invalidate
    ins_op(mk(20'd400, 8'd3, 8'd5, 2'd0, 0, 2'd0, 20'hC00, 2'd3, 2'b10));
    ins_op(mk(20'd401, 8'd4, 8'd5, 2'd0, 0, 2'd0, 20'hC01, 2'd3, 2'b10));
    ins_op(mk(20'd402, 8'd3, 8'd5, 2'd0, 1, 2'd0, 20'hC02, 2'd3, 2'b10));
    inv_op(0, 8'd5, 2'd0, 1, 8'd3, 0, '0);
    lookup_op(20'd400, 8'd3, 8'd5, 2'd0, 2'd0, 1, 0, '0, "R10 selected slot cleared");
    lookup_op(20'd401, 8'd4, 8'd5, 2'd0, 2'd0, 1, 0, '0, "R10 other asid kept");
    lookup_op(20'd402, 8'd3, 8'd5, 2'd0, 2'd0, 1, 0, '0, "R10 global kept");
    chk_cnt("R10 selective counters");
    inv_op(1, 8'd0, 2'd0, 0, 8'd0, 1, mk(20'd500, 8'd1, 8'd1, 2'd0, 0, 2'd0, 20'hD00, 2'd3, 2'b10));
    lk(20'd500, 8'd1, 8'd1, 2'd0, "R11 fill dropped under invalidate");
    lk(20'd401, 8'd4, 8'd5, 2'd0, "R10 all cleared");
    chk_cnt("R10 full counters");
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2", $sformatf("pending results got %0d exp 0", exp_q.size()));
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule